// File: doc/BRIEF.md
# Four-Register 8-bit Multicycle Processor Core

This block is a compact multicycle processor core with four interchangeable 8-bit working registers (A, B, C, D) and a program counter that software cannot name directly. It drives a 256-byte synchronous RAM through a single 8-bit address bus, with separate write-data and read-data buses and one write strobe. Read data is expected one clock after the address is presented. Each instruction is fetched, decoded and executed over three to four clocks. Every instruction is one byte, except load-immediate and the absolute and conditional jumps, which carry an immediate byte after the opcode.

Arithmetic and logic results come from a separate ALU block that also produces five condition flags: carry/borrow, zero, sign, signed overflow and signed-less. The flags are not readable. They steer the conditional jumps, one flag per jump. A debug port shows the program counter, all four registers and a marker for the fetch cycle, so a test harness can find instruction boundaries and detect a program parked in a jump-to-self loop.

Top module: `cpu8_core`

## Requirements
- R1: While reset is asserted, and until the first fetch after release, the PC and all registers read 0x00 and the flags are clear. No conditional jump is taken before the first flag-writing instruction. The first fetch reads address 0x00.
- R2: In a fetch cycle the core drives the PC on mem_addr and increments the PC. A one-byte instruction that touches only registers takes exactly 3 clocks from its fetch to the next fetch. A register-indirect load takes 4 clocks.
- R3: ldi, jmpi and the conditional jumps read their immediate from the byte after the opcode and take 4 clocks from fetch to fetch. ldi writes the immediate into register x and advances the PC past it. jmpi loads the PC with the immediate.
- R4: Opcode bits [7:4] select the operation: 0 cpr, 1 ld, 2 st, 3 ldi, 4 jmpi, 5 conditional jump, 6 jmp, 7 cmp, 8 add, 9 sub, A and, B or, C not, D rsh, E inc, F dec. Bits [3:2] name register x and bits [1:0] name register y, with A=0, B=1, C=2, D=3. Single-operand instructions use the x field.
- R5: For a conditional jump, opcode bits [3:0] equal to 0, 1, 2, 3 or 4 test C, Z, S, O or L respectively. If the flag is set, the PC becomes the immediate. Otherwise execution continues at the byte after the immediate.
- R6: ld x,(y) loads x from the RAM byte addressed by y. st (y),x writes x to the RAM byte addressed by y. No other register changes.
- R7: jmp x loads the PC from register x.
- R8: add and sub write x = x+y and x = x-y. cmp computes x-y without writing a register. All three set C (carry out for add, borrow i.e. unsigned x<y for sub and cmp), Z (result zero), S (result bit 7), O (signed overflow) and L = S xor O.
- R9: and, or, not and rsh (logical right shift of x by the unsigned amount in y, giving 0 for amounts of 8 or more) write x. They set Z and S from the result and set L = S, and they leave C and O unchanged.
- R10: cpr x,y copies y into x. inc and dec add or subtract 1 modulo 256. None of the three changes any flag.
- R11: A conditional-jump opcode whose low nibble is 5 to 15 acts as a one-byte no-operation taking 3 clocks. It changes no register and does not consume the following byte.
- R12: mem_we is high only in the execute cycle of st, for exactly one clock per store.
- R13: dbg_pc shows the PC. dbg_regs shows A in bits [7:0], B in [15:8], C in [23:16] and D in [31:24]. dbg_fetch is high exactly in fetch cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 8 | RAM address for fetch, immediate, load and store |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one clock after the address |
| dbg_pc | output | 8 | Current program counter |
| dbg_regs | output | 32 | Registers A..D packed from the low byte up |
| dbg_fetch | output | 1 | High during a fetch cycle |

## Verification
A register result is written at the clock that ends the execute cycle, which is the third clock after the fetch. A loaded value or immediate lands one clock later. A store's write lands at the end of its execute cycle, and a flag result is visible to the next instruction's jump. The bench never times a result cycle by cycle. It runs each small program until the fetch marker shows the same PC twice in a row, which means every earlier instruction has retired, and then compares registers and RAM with values it computes arithmetically. Instruction lengths are checked separately: the bench records the clock of each first fetch at a given PC and compares the gaps with 3 and 4 clocks.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int unsigned XLEN = 8;
  localparam int unsigned NREG = 4;
  localparam int unsigned RSEL = $clog2(NREG);
  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] COND_MAX = 4'd4;

  typedef enum logic [OPW-1:0] {
    OP_CPR  = 4'h0,
    OP_LD   = 4'h1,
    OP_ST   = 4'h2,
    OP_LDI  = 4'h3,
    OP_JMPI = 4'h4,
    OP_JCC  = 4'h5,
    OP_JMP  = 4'h6,
    OP_CMP  = 4'h7,
    OP_ADD  = 4'h8,
    OP_SUB  = 4'h9,
    OP_AND  = 4'hA,
    OP_OR   = 4'hB,
    OP_NOT  = 4'hC,
    OP_RSH  = 4'hD,
    OP_INC  = 4'hE,
    OP_DEC  = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    AL_PASS, AL_ADD, AL_SUB, AL_AND, AL_OR, AL_NOT, AL_RSH, AL_INC, AL_DEC
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
    logic l;
  } flags_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMRD, ST_IMM
  } state_e;
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  flags_t          fin,
  output logic [XLEN-1:0] res,
  output flags_t          fout
);
  localparam int unsigned MSB = XLEN - 1;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN:0] sum_w;
  logic [XLEN:0] diff_w;
  logic          upd_zs;
  logic          arith;

  assign sum_w  = {1'b0, opa} + {1'b0, opb};
  assign diff_w = {1'b0, opa} - {1'b0, opb};

  always_comb begin
    res    = opa;
    fout   = fin;
    upd_zs = 1'b0;
    arith  = 1'b0;
    unique case (op)
      AL_PASS: res = opb;
      AL_ADD: begin
        res    = sum_w[XLEN-1:0];
        fout.c = sum_w[XLEN];
        fout.o = (opa[MSB] == opb[MSB]) && (sum_w[MSB] != opa[MSB]);
        upd_zs = 1'b1;
        arith  = 1'b1;
      end
      AL_SUB: begin
        res    = diff_w[XLEN-1:0];
        fout.c = diff_w[XLEN];
        fout.o = (opa[MSB] != opb[MSB]) && (diff_w[MSB] != opa[MSB]);
        upd_zs = 1'b1;
        arith  = 1'b1;
      end
      AL_AND: begin res = opa & opb;  upd_zs = 1'b1; end
      AL_OR:  begin res = opa | opb;  upd_zs = 1'b1; end
      AL_NOT: begin res = ~opa;       upd_zs = 1'b1; end
      AL_RSH: begin res = opa >> opb; upd_zs = 1'b1; end
      AL_INC: res = opa + ONE;
      AL_DEC: res = opa - ONE;
      default: res = opa;
    endcase
    if (upd_zs) begin
      fout.z = (res == '0);
      fout.s = res[MSB];
      fout.l = arith ? (res[MSB] ^ fout.o) : res[MSB];
    end
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
  import cpu8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RSEL-1:0]      waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [RSEL-1:0]      raddr_x,
  input  logic [RSEL-1:0]      raddr_y,
  output logic [XLEN-1:0]      rdata_x,
  output logic [XLEN-1:0]      rdata_y,
  output logic [NREG*XLEN-1:0] regs_flat
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic wen;
    assign wen = we && (waddr == RSEL'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (wen) begin
        regs_q[i] <= wdata;
      end
    end
    assign regs_flat[i*XLEN +: XLEN] = regs_q[i];
  end

  assign rdata_x = regs_q[raddr_x];
  assign rdata_y = regs_q[raddr_y];

  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q));
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] rd_x,
  input  logic [XLEN-1:0] rd_y,
  input  logic [XLEN-1:0] alu_res,
  input  flags_t          alu_flags,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  output logic [RSEL-1:0] sel_x,
  output logic [RSEL-1:0] sel_y,
  output logic            rf_we,
  output logic [XLEN-1:0] rf_wdata,
  output alu_op_e         alu_op,
  output flags_t          flags,
  output logic [XLEN-1:0] pc,
  output logic            at_fetch
);
  localparam logic [XLEN-1:0] PC_ONE = {{(XLEN-1){1'b0}}, 1'b1};

  state_e          state_q, state_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q;
  flags_t          flags_q, flags_d;
  logic            pc_en, ir_en, fl_en;
  opcode_e         op;
  logic [3:0]      cond;
  logic            cond_ok;
  logic            taken;

  assign op    = opcode_e'(ir_q[7:4]);
  assign sel_x = ir_q[3:2];
  assign sel_y = ir_q[1:0];
  assign cond  = ir_q[3:0];
  assign cond_ok = (cond <= COND_MAX);

  always_comb begin
    unique case (cond)
      4'd0:    taken = flags_q.c;
      4'd1:    taken = flags_q.z;
      4'd2:    taken = flags_q.s;
      4'd3:    taken = flags_q.o;
      4'd4:    taken = flags_q.l;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    pc_en     = 1'b0;
    ir_en     = 1'b0;
    fl_en     = 1'b0;
    flags_d   = alu_flags;
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = rd_x;
    rf_we     = 1'b0;
    rf_wdata  = alu_res;
    alu_op    = AL_PASS;
    unique case (state_q)
      ST_FETCH: begin
        pc_d    = pc_q + PC_ONE;
        pc_en   = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        unique case (op)
          OP_CPR: begin alu_op = AL_PASS; rf_we = 1'b1; end
          OP_LD: begin
            mem_addr = rd_y;
            state_d  = ST_MEMRD;
          end
          OP_ST: begin
            mem_addr = rd_y;
            mem_we   = 1'b1;
          end
          OP_LDI, OP_JMPI: state_d = ST_IMM;
          OP_JCC: if (cond_ok) state_d = ST_IMM;
          OP_JMP: begin pc_d = rd_x; pc_en = 1'b1; end
          OP_CMP: begin alu_op = AL_SUB; fl_en = 1'b1; end
          OP_ADD: begin alu_op = AL_ADD; fl_en = 1'b1; rf_we = 1'b1; end
          OP_SUB: begin alu_op = AL_SUB; fl_en = 1'b1; rf_we = 1'b1; end
          OP_AND: begin alu_op = AL_AND; fl_en = 1'b1; rf_we = 1'b1; end
          OP_OR:  begin alu_op = AL_OR;  fl_en = 1'b1; rf_we = 1'b1; end
          OP_NOT: begin alu_op = AL_NOT; fl_en = 1'b1; rf_we = 1'b1; end
          OP_RSH: begin alu_op = AL_RSH; fl_en = 1'b1; rf_we = 1'b1; end
          OP_INC: begin alu_op = AL_INC; rf_we = 1'b1; end
          OP_DEC: begin alu_op = AL_DEC; rf_we = 1'b1; end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_MEMRD: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
        state_d  = ST_FETCH;
      end
      ST_IMM: begin
        state_d = ST_FETCH;
        pc_en   = 1'b1;
        unique case (op)
          OP_LDI: begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
            pc_d     = pc_q + PC_ONE;
          end
          OP_JMPI: pc_d = mem_rdata;
          default: pc_d = taken ? mem_rdata : (pc_q + PC_ONE);
        endcase
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q    <= pc_d;
      if (ir_en) ir_q    <= mem_rdata;
      if (fl_en) flags_q <= flags_d;
    end
  end

  assign flags    = flags_q;
  assign pc       = pc_q;
  assign at_fetch = (state_q == ST_FETCH);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
  // R2
  fetch_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_ONE));
  // R12
  write_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (state_q == ST_FETCH));
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_EXEC) |=> $stable(flags_q));
  // R9
  logic_keeps_co_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && (op == OP_AND || op == OP_OR || op == OP_NOT || op == OP_RSH))
    |=> (flags_q.c == $past(flags_q.c) && flags_q.o == $past(flags_q.o)));
  // R11
  nop_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && op == OP_JCC && !cond_ok) |=> ($stable(pc_q) && state_q == ST_FETCH));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [XLEN-1:0]      mem_addr,
  output logic                 mem_we,
  output logic [XLEN-1:0]      mem_wdata,
  input  logic [XLEN-1:0]      mem_rdata,
  output logic [XLEN-1:0]      dbg_pc,
  output logic [NREG*XLEN-1:0] dbg_regs,
  output logic                 dbg_fetch
);
  logic [RST_SYNC_STAGES-1:0] rst_sync_q;
  logic                       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q[0] <= 1'b1;
      for (int i = 1; i < RST_SYNC_STAGES; i++) begin
        rst_sync_q[i] <= rst_sync_q[i-1];
      end
    end
  end
  assign core_rst_n = rst_sync_q[RST_SYNC_STAGES-1];

  logic [RSEL-1:0] sel_x, sel_y;
  logic [XLEN-1:0] rd_x, rd_y;
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;
  alu_op_e         alu_op;
  logic [XLEN-1:0] alu_res;
  flags_t          alu_flags;
  flags_t          flags;

  cpu8_regfile u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .we        (rf_we),
    .waddr     (sel_x),
    .wdata     (rf_wdata),
    .raddr_x   (sel_x),
    .raddr_y   (sel_y),
    .rdata_x   (rd_x),
    .rdata_y   (rd_y),
    .regs_flat (dbg_regs)
  );

  cpu8_alu u_alu (
    .op   (alu_op),
    .opa  (rd_x),
    .opb  (rd_y),
    .fin  (flags),
    .res  (alu_res),
    .fout (alu_flags)
  );

  cpu8_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .mem_rdata (mem_rdata),
    .rd_x      (rd_x),
    .rd_y      (rd_y),
    .alu_res   (alu_res),
    .alu_flags (alu_flags),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .sel_x     (sel_x),
    .sel_y     (sel_y),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata),
    .alu_op    (alu_op),
    .flags     (flags),
    .pc        (dbg_pc),
    .at_fetch  (dbg_fetch)
  );
endmodule

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  dbg_pc;
  logic [31:0] dbg_regs;
  logic        dbg_fetch;

  always #4 clk = ~clk;

  cpu8_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc),
    .dbg_regs(dbg_regs), .dbg_fetch(dbg_fetch)
  );

  logic [7:0] mem [256];
  logic [7:0] img [256];
  logic       load_req;

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int total_cyc = 0;
  int fetch_at [256];
  int wr_count;
  int halt_pc;
  bit timed_out = 0;
  int plen;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int k);
    return dbg_regs[k*8 +: 8];
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    plen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    img[plen] = b;
    plen++;
  endtask

  task automatic run(input int max_cyc);
    int  n;
    bit  halted, prev_f, seen;
    int  prev_pc;
    @(negedge clk); rst_n = 1'b0; load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 256; i++) fetch_at[i] = -1;
    n = 0; halted = 0; prev_f = 0; seen = 0; prev_pc = -1; wr_count = 0;
    while (!halted && n < max_cyc && !timed_out) begin
      @(negedge clk);
      n++; total_cyc++;
      if (total_cyc > 195000) timed_out = 1;
      if (mem_we) wr_count++;
      if (dbg_fetch && !prev_f) begin
        if (fetch_at[dbg_pc] < 0) fetch_at[dbg_pc] = n;
        if (seen && int'(dbg_pc) == prev_pc) halted = 1;
        prev_pc = dbg_pc; seen = 1;
      end
      prev_f = dbg_fetch;
    end
    halt_pc = prev_pc;
    if (!halted) chk(1'b0, "R13", "watchdog expired", n, max_cyc);
  endtask

  // expected model; f = {l,o,s,z,c}
  function automatic void model(input int opc, input logic [7:0] x, input logic [7:0] y,
                                output logic [7:0] a_exp, output logic [4:0] f);
    logic c, z, s, o, l;
    logic [8:0] t;
    logic [7:0] r;
    c = 1; z = 0; s = 1; o = 1; l = 0;
    r = x; a_exp = x;
    case (opc)
      8: begin t = {1'b0,x} + {1'b0,y}; r = t[7:0]; c = t[8];
           o = (x[7] == y[7]) && (r[7] != x[7]); z = (r == 0); s = r[7]; l = s ^ o; a_exp = r; end
      9, 7: begin r = x - y; c = (x < y); o = (x[7] != y[7]) && (r[7] != x[7]);
           z = (r == 0); s = r[7]; l = s ^ o; a_exp = (opc == 9) ? r : x; end
      10, 11, 12, 13: begin
           if (opc == 10) r = x & y;
           else if (opc == 11) r = x | y;
           else if (opc == 12) r = ~x;
           else r = x >> y;
           z = (r == 0); s = r[7]; l = s; a_exp = r; end
      0:  a_exp = y;
      14: a_exp = x + 8'd1;
      15: a_exp = x - 8'd1;
      default: a_exp = x;
    endcase
    f = {l, o, s, z, c};
  endfunction

  function automatic string req_of(input int opc);
    if (opc == 7 || opc == 8 || opc == 9) return "R8";
    if (opc >= 10 && opc <= 13) return "R9";
    return "R10";
  endfunction

  task automatic sweep_one(input int opc, input logic [7:0] x, input logic [7:0] y);
    logic [7:0] a_exp; logic [4:0] f; logic [4:0] got;
    int base;
    clear_img();
    put(8'h30); put(x);          // ldi a,x
    put(8'h34); put(y);          // ldi b,y
    put(8'h38); put(8'h7F);      // ldi c,7F
    put(8'h3C); put(8'h80);      // ldi d,80
    put(8'h7B);                  // cmp c,d : C=1 Z=0 S=1 O=1 L=0
    put(8'h3C); put(8'hF0);      // ldi d,F0
    put({opc[3:0], 2'b00, 2'b01});
    for (int k = 0; k < 5; k++) begin
      base = plen;
      put(8'h38); put(8'h00);                 // ldi c,0
      put({4'h5, k[3:0]}); put(8'(base + 5)); // conditional jump
      put(8'hE8);                             // inc c
      put(8'h2B);                             // st (d),c
      put(8'hEC);                             // inc d
    end
    put(8'h23);                               // st (d),a
    put(8'h40); put(8'(plen - 1));            // halt loop
    run(600);
    model(opc, x, y, a_exp, f);
    for (int k = 0; k < 5; k++) got[k] = (mem[8'hF0 + k] == 8'h00);
    chk(rg(0) == a_exp, req_of(opc), $sformatf("op%0h x=%0h y=%0h result A", opc, x, y), rg(0), a_exp);
    chk(got == f, req_of(opc), $sformatf("op%0h x=%0h y=%0h flags LOSZC", opc, x, y), got, f);
    chk(rg(1) == y && mem[8'hF5] == a_exp, "R4", "operand B kept / stored result", {rg(1), mem[8'hF5]}, {y, a_exp});
  endtask

  logic [7:0] vals [10] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h7F, 8'h80, 8'h81, 8'hC3, 8'hFE, 8'hFF};
  int bin_ops [7] = '{0, 7, 8, 9, 10, 11, 13};
  int una_ops [3] = '{12, 14, 15};
  logic [7:0] rv [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};

  initial begin
    rst_n = 1'b0; load_req = 1'b0;
    clear_img();
    repeat (3) @(negedge clk);
    // R1 R13 reset state
    chk(dbg_pc == 8'h00 && dbg_regs == 32'h0, "R1", "reset pc/regs", {dbg_pc, dbg_regs}, 0);
    chk(dbg_fetch == 1'b1 && mem_addr == 8'h00 && mem_we == 1'b0, "R13", "reset fetch marker/addr/we",
        {dbg_fetch, mem_addr, mem_we}, 10'h200);

    // R1 R5: no jump taken on cleared flags
    clear_img();
    for (int k = 0; k < 5; k++) begin put({4'h5, k[3:0]}); put(8'h30); end
    put(8'h40); put(8'h0A);
    img[8'h30] = 8'h40; img[8'h31] = 8'h30;
    run(300);
    chk(halt_pc == 8'h0A, "R1", "flags clear after reset, all jumps fall through", halt_pc, 8'h0A);

    // R11 R2 R3: unused jump codes
    for (int c = 5; c < 16; c++) begin
      clear_img();
      put(8'h30); put(8'h12);     // ldi a,12
      put({4'h5, c[3:0]});        // unused
      put(8'hE0);                 // inc a
      put(8'h34); put(8'h05);     // ldi b,5
      put(8'h40); put(8'h06);
      run(300);
      chk(rg(0) == 8'h13 && rg(1) == 8'h05 && halt_pc == 6, "R11",
          $sformatf("code %0d as one-byte nop", c), {rg(0), rg(1)}, 16'h1305);
      chk(fetch_at[3] - fetch_at[2] == 3, "R11", "nop length in clocks", fetch_at[3] - fetch_at[2], 3);
      chk(fetch_at[4] - fetch_at[3] == 3, "R2", "inc length in clocks", fetch_at[4] - fetch_at[3], 3);
      chk(fetch_at[6] - fetch_at[4] == 4, "R3", "ldi length in clocks", fetch_at[6] - fetch_at[4], 4);
    end

    // R6 R4 R12: store plus add, every register pair
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        logic [7:0] e [4];
        clear_img();
        for (int r = 0; r < 4; r++) begin put({4'h3, r[1:0], 2'b00}); put(rv[r]); end
        put({4'h2, x[1:0], y[1:0]});   // st (y),x
        put({4'h8, x[1:0], y[1:0]});   // add x,y
        put(8'h40); put(8'h0A);
        run(300);
        for (int r = 0; r < 4; r++) e[r] = rv[r];
        e[x] = rv[x] + rv[y];
        chk(mem[rv[y]] == rv[x], "R6", $sformatf("st (%0d),%0d", y, x), mem[rv[y]], rv[x]);
        chk(dbg_regs == {e[3], e[2], e[1], e[0]}, "R4", $sformatf("add %0d,%0d register fields", x, y),
            dbg_regs, {e[3], e[2], e[1], e[0]});
        chk(wr_count == 1, "R12", "one write strobe per store", wr_count, 1);
      end
    end

    // R6 R2: load, every register pair
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        logic [7:0] e [4];
        clear_img();
        for (int r = 0; r < 4; r++) begin put({4'h3, r[1:0], 2'b00}); put(rv[r]); end
        put({4'h1, x[1:0], y[1:0]});   // ld x,(y)
        put(8'h40); put(8'h09);
        img[rv[y]] = rv[y] ^ 8'h5A;
        run(300);
        for (int r = 0; r < 4; r++) e[r] = rv[r];
        e[x] = rv[y] ^ 8'h5A;
        chk(dbg_regs == {e[3], e[2], e[1], e[0]}, "R6", $sformatf("ld %0d,(%0d)", x, y),
            dbg_regs, {e[3], e[2], e[1], e[0]});
        chk(fetch_at[9] - fetch_at[8] == 4 && wr_count == 0, "R2", "ld length / no write",
            fetch_at[9] - fetch_at[8], 4);
      end
    end

    // R7: jump through each register
    for (int x = 0; x < 4; x++) begin
      logic [7:0] t;
      t = 8'h40 + 8'(x * 16);
      clear_img();
      put({4'h3, x[1:0], 2'b00}); put(t);
      put({4'h6, x[1:0], 2'b00});
      put(8'h40); put(8'h03);
      img[t] = 8'h40; img[t + 8'd1] = t;
      run(300);
      chk(halt_pc == int'(t), "R7", $sformatf("jmp via reg %0d", x), halt_pc, t);
    end

    // R5 R8 R9 R10: operand sweeps with flag capture
    foreach (bin_ops[i]) begin
      foreach (vals[a]) begin
        foreach (vals[b]) begin
          if (!timed_out) sweep_one(bin_ops[i], vals[a], vals[b]);
        end
      end
    end
    foreach (una_ops[i]) begin
      foreach (vals[a]) begin
        if (!timed_out) sweep_one(una_ops[i], vals[a], 8'h5A);
      end
    end

    if (timed_out) chk(1'b0, "R13", "global watchdog", total_cyc, 195000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule